// File: doc/BRIEF.md
# SPI NOR flash command sequencer

This block is the byte-level command engine of an SPI NOR flash slave. A serial front end hands it one received byte per transfer, together with the chip-select level. The engine returns one response byte for each transfer. It decodes the first byte after selection as an opcode. It then gathers address, dummy and parameter bytes into a small buffer, answers register reads from that buffer, and drives a storage port with read, program and erase requests.

The engine holds the write-enable latch, the reset-enable latch, the 3-byte/4-byte address mode and a segment register. The segment register supplies address bits [25:24] when the address is 3 bytes long. It also holds three configuration registers: volatile, enhanced volatile and nonvolatile. The nonvolatile word seeds the two volatile registers, the address mode and the segment register at hardware reset and at a software reset.

The byte stream has no back-pressure. A byte is taken in every cycle in which `rx_valid` and `cs_active` are both high. Its response appears on `tx_data` with `tx_valid` high exactly one cycle later, and the consumer must take it then. The storage port is combinational: `mem_rdata` must reflect `mem_addr` within the same cycle that `mem_rd` is high.

Top module: `snor_cmd_engine`

## Requirements
- R1: After hardware reset, and after a software reset, write-enable and reset-enable are clear and the engine is idle. The volatile config takes these values: bits 1:0 = 11, bit 2 = 0, bit 3 = 1 unless nonvolatile bits [11:9] are 111, and bits [7:4] = nonvolatile [15:12]. The enhanced config takes these values: bits 4:0 = 11111, bit 5 = 0, bit 6 = nonvolatile bit 2, bit 7 = nonvolatile bit 3. 4-byte mode is on exactly when nonvolatile bit 0 is 0. The segment register is 3 when nonvolatile bit 1 is 0 and 0 otherwise. The hardware reset value of the nonvolatile word is 0x8FFF.
- R2: A byte taken in cycle N gives `tx_valid`=1 and its response on `tx_data` in cycle N+1. In every other cycle `tx_valid`=0 and `tx_data`=0x00. Opcode, address, dummy and write-data bytes respond 0x00.
- R3: Whenever `cs_active` is low the engine returns to idle, and bytes offered while it is low are ignored. After reselection, the first byte is decoded as an opcode.
- R4: 0x06 sets write-enable and 0x04 clears it. 0x05 returns one byte holding write-enable in bit 1 and zeros elsewhere. 0x70 returns one byte with bit 7 set and bit 0 equal to the 4-byte mode. 0xB7 enters 4-byte mode and 0xE9 leaves it.
- R5: 0x9F returns the 24-bit ID code, most significant byte first. The two bytes of the extended code follow, high byte first, only when that code is nonzero. After the last returned byte the next byte is decoded as an opcode.
- R6: 0x03 takes 3 address bytes (4 in 4-byte mode), most significant first. Each later byte pulses `mem_rd` at the current address, returns `mem_rdata`, and advances the address by one.
- R7: With 3-byte addresses, (segment & 3) × 2^24 is added to the address. 0xC8 returns the segment register. 0xC5 writes it from the next byte, but only when write-enable is set.
- R8: 0x0B collects the address bytes plus a number of dummy bytes equal to volatile config bits [7:4]. It then reads as in R6.
- R9: 0x02 takes an address as in R6. Each later byte advances the address and, only when write-enable is set, pulses `mem_wr` with that byte on `mem_wdata` at the current address.
- R10: 0xD8 takes an address. When write-enable is set, `mem_erase` pulses for exactly one cycle, in the cycle after the last address byte, with `mem_addr` holding the assembled address. Otherwise no erase is issued.
- R11: 0x66 sets reset-enable and any other opcode clears it. 0x99 applies the software reset of R1 only when reset-enable is set.
- R12: 0x85, 0x65 and 0xB5 read the volatile, enhanced and nonvolatile configs; the nonvolatile config is returned low byte first. 0x81, 0x61 and 0xB1 write them, the last taking the low byte first; each write is taken only when write-enable is set. Any undefined opcode returns 0x00 and leaves the engine idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_active | input | 1 | Chip select, high while the device is selected |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Response byte present, one cycle after the byte is taken |
| tx_data | output | 8 | Response byte, 0x00 when not valid |
| mem_rd | output | 1 | Storage read strobe |
| mem_wr | output | 1 | Storage program strobe |
| mem_erase | output | 1 | Sector erase strobe |
| mem_addr | output | ADDR_W | Storage byte address |
| mem_wdata | output | 8 | Program data |
| mem_rdata | input | 8 | Storage read data, combinational from mem_addr |

## Verification
A wrong opcode decode or a wrong collect count shows on the next response byte. A byte that should be answered returns 0x00, or a read or program strobe lands one byte early or late, so the fault is visible at the port within one transfer. A corrupted latch, address mode or configuration register stays hidden until it is read back through a status or configuration opcode, or until it changes the address length or the number of dummy bytes. The bench therefore reads each register back right after the commands that alter it. A lost or doubled erase pulse appears on `mem_erase` one cycle after the address completes.

// File: rtl/snor_pkg.sv
package snor_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_READ,
    ST_COLLECT,
    ST_REPLY
  } eng_state_t;

  typedef struct packed {
    logic        wel;
    logic        ren;
    logic        addr4;
    logic [7:0]  seg;
    logic [15:0] nv;
    logic [7:0]  vcfg;
    logic [7:0]  ecfg;
  } cfg_state_t;

  localparam logic [7:0] OP_WREN      = 8'h06;
  localparam logic [7:0] OP_WRDI      = 8'h04;
  localparam logic [7:0] OP_RDSR      = 8'h05;
  localparam logic [7:0] OP_RDFLAG    = 8'h70;
  localparam logic [7:0] OP_RDID      = 8'h9F;
  localparam logic [7:0] OP_READ      = 8'h03;
  localparam logic [7:0] OP_FREAD     = 8'h0B;
  localparam logic [7:0] OP_PROG      = 8'h02;
  localparam logic [7:0] OP_SERASE    = 8'hD8;
  localparam logic [7:0] OP_A4_ON     = 8'hB7;
  localparam logic [7:0] OP_A4_OFF    = 8'hE9;
  localparam logic [7:0] OP_SEG_RD    = 8'hC8;
  localparam logic [7:0] OP_SEG_WR    = 8'hC5;
  localparam logic [7:0] OP_VCFG_RD   = 8'h85;
  localparam logic [7:0] OP_VCFG_WR   = 8'h81;
  localparam logic [7:0] OP_ECFG_RD   = 8'h65;
  localparam logic [7:0] OP_ECFG_WR   = 8'h61;
  localparam logic [7:0] OP_NVCFG_RD  = 8'hB5;
  localparam logic [7:0] OP_NVCFG_WR  = 8'hB1;
  localparam logic [7:0] OP_RST_ARM   = 8'h66;
  localparam logic [7:0] OP_RST_GO    = 8'h99;

  function automatic logic [7:0] vcfg_from_nv(input logic [15:0] n);
    return {n[15:12], (n[11:9] != 3'b111), 1'b0, 2'b11};
  endfunction

  function automatic logic [7:0] ecfg_from_nv(input logic [15:0] n);
    return {n[3], n[2], 1'b0, 5'b11111};
  endfunction

  function automatic logic [7:0] seg_from_nv(input logic [15:0] n);
    return n[1] ? 8'h00 : 8'h03;
  endfunction

endpackage

// File: rtl/snor_cfg_regs.sv
module snor_cfg_regs
  import snor_pkg::*;
#(
  parameter logic [15:0] NV_RESET = 16'h8FFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wel_set,
  input  logic        wel_clr,
  input  logic        ren_set,
  input  logic        ren_clr,
  input  logic        a4_set,
  input  logic        a4_clr,
  input  logic        soft_rst,
  input  logic        seg_wr,
  input  logic        vcfg_wr,
  input  logic        ecfg_wr,
  input  logic        nv_wr,
  input  logic [15:0] wr_data,
  output cfg_state_t  cfg
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg.nv    <= NV_RESET;
      cfg.vcfg  <= vcfg_from_nv(NV_RESET);
      cfg.ecfg  <= ecfg_from_nv(NV_RESET);
      cfg.seg   <= seg_from_nv(NV_RESET);
      cfg.addr4 <= ~NV_RESET[0];
      cfg.wel   <= 1'b0;
      cfg.ren   <= 1'b0;
    end else if (soft_rst) begin
      cfg.vcfg  <= vcfg_from_nv(cfg.nv);
      cfg.ecfg  <= ecfg_from_nv(cfg.nv);
      cfg.seg   <= seg_from_nv(cfg.nv);
      cfg.addr4 <= ~cfg.nv[0];
      cfg.wel   <= 1'b0;
      cfg.ren   <= 1'b0;
    end else begin
      if (wel_set)      cfg.wel <= 1'b1;
      else if (wel_clr) cfg.wel <= 1'b0;
      if (ren_set)      cfg.ren <= 1'b1;
      else if (ren_clr) cfg.ren <= 1'b0;
      if (a4_set)       cfg.addr4 <= 1'b1;
      else if (a4_clr)  cfg.addr4 <= 1'b0;
      if (seg_wr)  cfg.seg  <= wr_data[7:0];
      if (vcfg_wr) cfg.vcfg <= wr_data[7:0];
      if (ecfg_wr) cfg.ecfg <= wr_data[7:0];
      if (nv_wr)   cfg.nv   <= wr_data;
    end
  end

  // R11: a software reset leaves both latches clear
  a_r11_soft_rst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!cfg.wel && !cfg.ren));

  // R7: the segment register only moves on a write or a reset
  a_r7_seg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!seg_wr && !soft_rst) |=> $stable(cfg.seg));

  // R4: a set request lands unless a reset overrides it
  a_r4_wel_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wel_set && !soft_rst) |=> cfg.wel);

endmodule

// File: rtl/snor_byte_buf.sv
module snor_byte_buf #(
  parameter int DEPTH = 8,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_en,
  input  logic [DEPTH-1:0][7:0] load_vec,
  input  logic                  cap_en,
  input  logic [IW-1:0]         cap_idx,
  input  logic [7:0]            cap_byte,
  output logic [DEPTH-1:0][7:0] bytes_q
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        bytes_q[g] <= 8'h00;
      else if (load_en)
        bytes_q[g] <= load_vec[g];
      else if (cap_en && (cap_idx == IW'(g)))
        bytes_q[g] <= cap_byte;
    end
  end

  // a parallel load and a single-byte capture never coincide
  a_r2_buf_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_en && cap_en));

endmodule

// File: rtl/snor_cmd_engine.sv
module snor_cmd_engine
  import snor_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          BUF_DEPTH = 8,
  parameter logic [23:0] ID_CODE   = 24'h20BA18,
  parameter logic [15:0] ID_EXT    = 16'h1044,
  parameter logic [15:0] NV_RESET  = 16'h8FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_active,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              mem_erase,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);

  localparam int CNT_W = $clog2(4 + 16);
  localparam int BUF_IW = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;
  localparam int RL_W = $clog2(BUF_DEPTH + 1);

  eng_state_t  state, state_n;
  logic [7:0]  cmd, cmd_n;
  logic [CNT_W-1:0] need, need_n, cnt, cnt_n, alen;
  logic [RL_W-1:0]  pos, pos_n, rlen, rlen_n;
  logic [ADDR_W-1:0] cur_addr, addr_n, addr_asm;
  logic        erase_pend, erase_pend_n;
  logic [7:0]  resp;
  logic        take, done_collect;

  cfg_state_t cfg;
  logic wel_set, wel_clr, ren_set, ren_clr, a4_set, a4_clr, soft_rst;
  logic seg_wr, vcfg_wr, ecfg_wr, nv_wr;
  logic [15:0] wr_data;

  logic                      load_en, cap_en;
  logic [BUF_DEPTH-1:0][7:0] load_vec, bq;
  logic [7:0]                ab [4];

  snor_cfg_regs #(.NV_RESET(NV_RESET)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wel_set(wel_set), .wel_clr(wel_clr),
    .ren_set(ren_set), .ren_clr(ren_clr),
    .a4_set(a4_set), .a4_clr(a4_clr),
    .soft_rst(soft_rst),
    .seg_wr(seg_wr), .vcfg_wr(vcfg_wr), .ecfg_wr(ecfg_wr), .nv_wr(nv_wr),
    .wr_data(wr_data),
    .cfg(cfg)
  );

  snor_byte_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .load_en(load_en), .load_vec(load_vec),
    .cap_en(cap_en), .cap_idx(cnt[BUF_IW-1:0]), .cap_byte(rx_data),
    .bytes_q(bq)
  );

  assign take = cs_active && rx_valid;
  assign alen = cfg.addr4 ? CNT_W'(4) : CNT_W'(3);
  assign done_collect = (cnt + CNT_W'(1)) == need;

  // address bytes: the byte arriving now completes the buffered ones
  for (genvar i = 0; i < 4; i++) begin : g_ab
    assign ab[i] = (cnt == CNT_W'(i)) ? rx_data : bq[i];
  end

  assign addr_asm = cfg.addr4 ? ADDR_W'({ab[0], ab[1], ab[2], ab[3]})
                              : ADDR_W'({cfg.seg[1:0], ab[0], ab[1], ab[2]});

  always_comb begin
    state_n = state; cmd_n = cmd; need_n = need; cnt_n = cnt;
    pos_n = pos; rlen_n = rlen; addr_n = cur_addr; erase_pend_n = 1'b0;
    resp = 8'h00;
    wel_set = 1'b0; wel_clr = 1'b0; ren_set = 1'b0; ren_clr = 1'b0;
    a4_set = 1'b0; a4_clr = 1'b0; soft_rst = 1'b0;
    seg_wr = 1'b0; vcfg_wr = 1'b0; ecfg_wr = 1'b0; nv_wr = 1'b0;
    wr_data = (cmd == OP_NVCFG_WR) ? {rx_data, bq[0]} : {8'h00, rx_data};
    load_en = 1'b0; load_vec = '0; cap_en = 1'b0;
    mem_rd = 1'b0; mem_wr = 1'b0;

    if (!cs_active) begin
      state_n = ST_IDLE;
    end else if (rx_valid) begin
      unique case (state)
        ST_IDLE: begin
          cmd_n = rx_data; cnt_n = '0; pos_n = '0;
          if (rx_data != OP_RST_GO) ren_clr = 1'b1;
          case (rx_data)
            OP_WREN:   wel_set = 1'b1;
            OP_WRDI:   wel_clr = 1'b1;
            OP_A4_ON:  a4_set = 1'b1;
            OP_A4_OFF: a4_clr = 1'b1;
            OP_RST_ARM: ren_set = 1'b1;
            OP_RST_GO:  soft_rst = cfg.ren;
            OP_RDSR: begin
              load_en = 1'b1; load_vec[0] = {6'b0, cfg.wel, 1'b0};
              rlen_n = RL_W'(1); state_n = ST_REPLY;
            end
            OP_RDFLAG: begin
              load_en = 1'b1; load_vec[0] = {7'b1000000, cfg.addr4};
              rlen_n = RL_W'(1); state_n = ST_REPLY;
            end
            OP_RDID: begin
              load_en = 1'b1;
              load_vec[0] = ID_CODE[23:16];
              load_vec[1] = ID_CODE[15:8];
              load_vec[2] = ID_CODE[7:0];
              load_vec[3] = ID_EXT[15:8];
              load_vec[4] = ID_EXT[7:0];
              rlen_n = (ID_EXT != 16'h0000) ? RL_W'(5) : RL_W'(3);
              state_n = ST_REPLY;
            end
            OP_SEG_RD: begin
              load_en = 1'b1; load_vec[0] = cfg.seg;
              rlen_n = RL_W'(1); state_n = ST_REPLY;
            end
            OP_VCFG_RD: begin
              load_en = 1'b1; load_vec[0] = cfg.vcfg;
              rlen_n = RL_W'(1); state_n = ST_REPLY;
            end
            OP_ECFG_RD: begin
              load_en = 1'b1; load_vec[0] = cfg.ecfg;
              rlen_n = RL_W'(1); state_n = ST_REPLY;
            end
            OP_NVCFG_RD: begin
              load_en = 1'b1;
              load_vec[0] = cfg.nv[7:0];
              load_vec[1] = cfg.nv[15:8];
              rlen_n = RL_W'(2); state_n = ST_REPLY;
            end
            OP_READ, OP_PROG, OP_SERASE: begin
              need_n = alen; state_n = ST_COLLECT;
            end
            OP_FREAD: begin
              need_n = alen + CNT_W'(cfg.vcfg[7:4]); state_n = ST_COLLECT;
            end
            OP_SEG_WR, OP_VCFG_WR, OP_ECFG_WR: begin
              if (cfg.wel) begin
                need_n = CNT_W'(1); state_n = ST_COLLECT;
              end
            end
            OP_NVCFG_WR: begin
              if (cfg.wel) begin
                need_n = CNT_W'(2); state_n = ST_COLLECT;
              end
            end
            default: ;
          endcase
        end

        ST_COLLECT: begin
          cap_en = cnt < CNT_W'(BUF_DEPTH);
          cnt_n = cnt + CNT_W'(1);
          if (done_collect) begin
            state_n = ST_IDLE;
            case (cmd)
              OP_READ, OP_FREAD: begin addr_n = addr_asm; state_n = ST_READ; end
              OP_PROG:   begin addr_n = addr_asm; state_n = ST_PROG; end
              OP_SERASE: begin addr_n = addr_asm; erase_pend_n = cfg.wel; end
              OP_SEG_WR:   seg_wr = 1'b1;
              OP_VCFG_WR:  vcfg_wr = 1'b1;
              OP_ECFG_WR:  ecfg_wr = 1'b1;
              OP_NVCFG_WR: nv_wr = 1'b1;
              default: ;
            endcase
          end
        end

        ST_REPLY: begin
          resp = bq[pos[BUF_IW-1:0]];
          pos_n = pos + RL_W'(1);
          if (pos + RL_W'(1) == rlen) state_n = ST_IDLE;
        end

        ST_READ: begin
          mem_rd = 1'b1;
          resp = mem_rdata;
          addr_n = cur_addr + ADDR_W'(1);
        end

        ST_PROG: begin
          mem_wr = cfg.wel;
          addr_n = cur_addr + ADDR_W'(1);
        end

        default: state_n = ST_IDLE;
      endcase
    end
  end

  assign mem_addr  = cur_addr;
  assign mem_wdata = rx_data;
  assign mem_erase = erase_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE; cmd <= 8'h00; need <= '0; cnt <= '0;
      pos <= '0; rlen <= '0; cur_addr <= '0; erase_pend <= 1'b0;
      tx_valid <= 1'b0; tx_data <= 8'h00;
    end else begin
      state <= state_n; cmd <= cmd_n; need <= need_n; cnt <= cnt_n;
      pos <= pos_n; rlen <= rlen_n; cur_addr <= addr_n;
      erase_pend <= erase_pend_n;
      tx_valid <= take;
      tx_data  <= take ? resp : 8'h00;
    end
  end

  // R2: every taken byte is answered on the following cycle
  a_r2_answer: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> tx_valid);
  // R2: no byte taken, nothing presented
  a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> (!tx_valid && tx_data == 8'h00));
  // R3: deselect always lands in idle
  a_r3_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |=> state == ST_IDLE);
  // R9: program strobe only with write-enable held
  a_r9_wr_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> cfg.wel);
  // R10: erase is a single-cycle pulse
  a_r10_erase_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_erase |=> !mem_erase);
  // R6: read and program never share a cycle
  a_r6_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !mem_wr);
  // R8: the collect counter stays below its target
  a_r8_collect_bound: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_COLLECT |-> cnt < need);
  // R5: the reply pointer stays inside the loaded bytes
  a_r5_reply_bound: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_REPLY |-> pos < rlen);

endmodule

// File: tb/sim_snor_cmd_engine.sv
`timescale 1ns/1ps
module sim_snor_cmd_engine;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_active = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic tx_valid, mem_rd, mem_wr, mem_erase;
  logic [7:0] tx_data, mem_wdata, mem_rdata;
  logic [31:0] mem_addr;

  always #4 clk = ~clk;

  function automatic logic [7:0] rdpat(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[31:24] ^ 8'hA5;
  endfunction

  assign mem_rdata = rdpat(mem_addr);

  snor_cmd_engine u0 (
    .clk(clk), .rst_n(rst_n), .cs_active(cs_active),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_data(tx_data),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_erase(mem_erase),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  localparam int M_IDLE = 0, M_PROG = 1, M_READ = 2, M_COL = 3, M_REP = 4;
  int ms = M_IDLE;
  logic [7:0] mcmd;
  int mneed, mcnt, mpos, mrlen;
  logic [7:0] mbuf [8];
  logic [31:0] maddr = 0;
  bit mwel, mren, m4, mep;
  logic [7:0] mseg, mvc, mec;
  logic [15:0] mnv = 16'h8FFF;

  bit exp_tv = 0, exp_rd = 0, exp_wr = 0, exp_er = 0;
  logic [7:0] exp_td = 0;
  logic [31:0] exp_addr = 0;

  task automatic mreload();
    mvc = 8'h03 | ((mnv[11:9] != 3'b111) ? 8'h08 : 8'h00) | {mnv[15:12], 4'h0};
    mec = 8'h1F | (mnv[2] ? 8'h40 : 8'h00) | (mnv[3] ? 8'h80 : 8'h00);
    m4 = !mnv[0];
    mseg = mnv[1] ? 8'h00 : 8'h03;
    mwel = 0; mren = 0; ms = M_IDLE;
  endtask

  task automatic mreply(input logic [7:0] b0, input logic [7:0] b1, input int n);
    mbuf[0] = b0; mbuf[1] = b1; mrlen = n; mpos = 0; ms = M_REP;
  endtask

  task automatic model(input bit c, input bit v, input logic [7:0] b);
    logic [31:0] a;
    exp_er = mep; exp_addr = maddr; mep = 0;
    exp_rd = 0; exp_wr = 0; exp_tv = c && v; exp_td = 8'h00;
    if (!c) begin ms = M_IDLE; return; end
    if (!v) return;
    case (ms)
      M_IDLE: begin
        mcmd = b; mcnt = 0;
        if (b != 8'h99) mren = 0;
        case (b)
          8'h06: mwel = 1;
          8'h04: mwel = 0;
          8'hB7: m4 = 1;
          8'hE9: m4 = 0;
          8'h66: mren = 1;
          8'h99: if (mren) mreload();
          8'h05: mreply({6'b0, mwel, 1'b0}, 8'h00, 1);
          8'h70: mreply({7'b1000000, m4}, 8'h00, 1);
          8'h9F: begin
            mbuf[0] = 8'h20; mbuf[1] = 8'hBA; mbuf[2] = 8'h18;
            mbuf[3] = 8'h10; mbuf[4] = 8'h44; mrlen = 5; mpos = 0; ms = M_REP;
          end
          8'hC8: mreply(mseg, 8'h00, 1);
          8'h85: mreply(mvc, 8'h00, 1);
          8'h65: mreply(mec, 8'h00, 1);
          8'hB5: mreply(mnv[7:0], mnv[15:8], 2);
          8'h03, 8'h02, 8'hD8: begin mneed = m4 ? 4 : 3; ms = M_COL; end
          8'h0B: begin mneed = (m4 ? 4 : 3) + int'(mvc[7:4]); ms = M_COL; end
          8'hC5, 8'h81, 8'h61: if (mwel) begin mneed = 1; ms = M_COL; end
          8'hB1: if (mwel) begin mneed = 2; ms = M_COL; end
          default: ;
        endcase
      end
      M_COL: begin
        if (mcnt < 8) mbuf[mcnt] = b;
        mcnt++;
        if (mcnt == mneed) begin
          ms = M_IDLE;
          a = m4 ? {mbuf[0], mbuf[1], mbuf[2], mbuf[3]}
                 : {6'b0, mseg[1:0], mbuf[0], mbuf[1], mbuf[2]};
          case (mcmd)
            8'h03, 8'h0B: begin maddr = a; ms = M_READ; end
            8'h02: begin maddr = a; ms = M_PROG; end
            8'hD8: begin maddr = a; mep = mwel; end
            8'hC5: mseg = b;
            8'h81: mvc = b;
            8'h61: mec = b;
            8'hB1: mnv = {b, mbuf[0]};
            default: ;
          endcase
        end
      end
      M_REP: begin
        exp_td = mbuf[mpos]; mpos++;
        if (mpos == mrlen) ms = M_IDLE;
      end
      M_READ: begin
        exp_rd = 1; exp_addr = maddr; exp_td = rdpat(maddr); maddr++;
      end
      M_PROG: begin
        exp_wr = mwel; exp_addr = maddr; maddr++;
      end
      default: ;
    endcase
  endtask

  // one clock: check last response, drive, check storage port
  task automatic step(input bit c, input bit v, input logic [7:0] b);
    @(negedge clk);
    chk("tx_valid", 32'(tx_valid), 32'(exp_tv));
    chk("tx_data", 32'(tx_data), 32'(exp_td));
    cs_active = c; rx_valid = v; rx_data = b;
    #1;
    model(c, v, b);
    chk("mem_rd", 32'(mem_rd), 32'(exp_rd));
    chk("mem_wr", 32'(mem_wr), 32'(exp_wr));
    chk("mem_erase", 32'(mem_erase), 32'(exp_er));
    if (exp_rd || exp_wr || exp_er) chk("mem_addr", mem_addr, exp_addr);
    if (exp_wr) chk("mem_wdata", 32'(mem_wdata), 32'(b));
  endtask

  logic [7:0] seq[$];

  task automatic run_seq();
    foreach (seq[i]) step(1'b1, 1'b1, seq[i]);
    step(1'b0, 1'b0, 8'h00);
  endtask

  initial begin
    mreload();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cur_req = "R1";   // reset values read back
    step(0, 0, 0);
    seq = '{8'h85, 8'h00}; run_seq();
    seq = '{8'h65, 8'h00}; run_seq();
    seq = '{8'hB5, 8'h00, 8'h00}; run_seq();
    seq = '{8'h05, 8'h00}; run_seq();
    seq = '{8'hC8, 8'h00}; run_seq();

    cur_req = "R4";
    seq = '{8'h70, 8'h00}; run_seq();
    seq = '{8'h06}; run_seq();
    seq = '{8'h05, 8'h00}; run_seq();
    seq = '{8'h04}; run_seq();
    seq = '{8'h05, 8'h00}; run_seq();
    seq = '{8'hB7}; run_seq();
    seq = '{8'h70, 8'h00}; run_seq();

    cur_req = "R6";   // 4-byte read, then 3-byte read
    seq = '{8'h03, 8'h12, 8'h34, 8'h56, 8'h78, 8'h00, 8'h00, 8'h00}; run_seq();
    seq = '{8'hE9}; run_seq();
    seq = '{8'h03, 8'h00, 8'hFF, 8'hFE, 8'h00, 8'h00, 8'h00, 8'h00}; run_seq();

    cur_req = "R5";   // five ID bytes, then an opcode again
    seq = '{8'h9F, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h05, 8'h00}; run_seq();

    cur_req = "R2";   // gaps inside a command
    step(1, 1, 8'h9F); step(1, 0, 8'h00); step(1, 1, 8'h00);
    step(1, 0, 8'h00); step(1, 0, 8'h00); step(1, 1, 8'h00);
    step(0, 0, 0);

    cur_req = "R7";
    seq = '{8'hC5, 8'h01}; run_seq();       // refused, no write-enable
    seq = '{8'hC8, 8'h00}; run_seq();
    seq = '{8'h06}; run_seq();
    seq = '{8'hC5, 8'h02}; run_seq();
    seq = '{8'hC8, 8'h00}; run_seq();
    seq = '{8'h03, 8'h00, 8'h10, 8'h20, 8'h00, 8'h00}; run_seq();

    cur_req = "R8";   // 8 dummy bytes by default
    seq = '{8'h0B, 8'h01, 8'h02, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00,
            8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}; run_seq();
    seq = '{8'h81, 8'h23}; run_seq();
    seq = '{8'h85, 8'h00}; run_seq();
    seq = '{8'h0B, 8'hAA, 8'hBB, 8'hCC, 8'h00, 8'h00, 8'h00, 8'h00}; run_seq();

    cur_req = "R9";
    seq = '{8'h02, 8'h00, 8'h00, 8'h40, 8'h11, 8'h22, 8'h33}; run_seq();
    seq = '{8'h04}; run_seq();
    seq = '{8'h02, 8'h00, 8'h00, 8'h80, 8'h44, 8'h55}; run_seq();

    cur_req = "R10";
    seq = '{8'hD8, 8'h00, 8'h01, 8'h00, 8'h05, 8'h00}; run_seq();
    seq = '{8'h06}; run_seq();
    seq = '{8'hD8, 8'h00, 8'h03, 8'h00, 8'h05, 8'h00}; run_seq();

    cur_req = "R3";   // drop select mid-address, bytes while deselected
    step(1, 1, 8'h03); step(1, 1, 8'h00); step(0, 1, 8'h05); step(0, 1, 8'h9F);
    step(1, 1, 8'h05); step(1, 1, 8'h00); step(0, 0, 0);

    cur_req = "R11";  // interrupted arm, then a real reset
    seq = '{8'h66}; run_seq();
    seq = '{8'h05, 8'h00}; run_seq();
    seq = '{8'h99}; run_seq();
    seq = '{8'h05, 8'h00}; run_seq();
    seq = '{8'h66}; run_seq();
    seq = '{8'h99}; run_seq();
    seq = '{8'h05, 8'h00}; run_seq();
    seq = '{8'h85, 8'h00}; run_seq();

    cur_req = "R12";  // nonvolatile write feeds the next reset
    seq = '{8'hB1, 8'hF0, 8'h3A}; run_seq();   // refused
    seq = '{8'h06}; run_seq();
    seq = '{8'h61, 8'h5C}; run_seq();
    seq = '{8'h65, 8'h00}; run_seq();
    seq = '{8'hB1, 8'hF0, 8'h3A}; run_seq();
    seq = '{8'hB5, 8'h00, 8'h00}; run_seq();
    seq = '{8'h5A, 8'h05, 8'h00}; run_seq();

    cur_req = "R1";   // reset derived from the new nonvolatile word
    seq = '{8'h66}; run_seq();
    seq = '{8'h99}; run_seq();
    seq = '{8'h70, 8'h00}; run_seq();
    seq = '{8'hC8, 8'h00}; run_seq();
    seq = '{8'h85, 8'h00}; run_seq();
    seq = '{8'h65, 8'h00}; run_seq();
    cur_req = "R7";
    seq = '{8'hE9}; run_seq();
    seq = '{8'h03, 8'h00, 8'h00, 8'h07, 8'h00}; run_seq();

    step(0, 0, 0);
    step(0, 0, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL %s watchdog actual=hung expected=finished", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule